// File: doc/BRIEF.md
# Host Byte Port to 16-bit Data Register

This block sits between an 8-bit host processor bus and the 16-bit data and status registers of a signal-processing core. The host sees two locations selected by a one-bit address: the status location, which returns the upper byte of the status register, and the data location, through which the host moves the 16-bit data register one byte at a time. The port keeps a request flag and a byte-phase flag inside the status register. The host polls the request flag to learn when the core has produced or consumed a word.

A width-select bit in the status register sets how data is moved. When it is clear, a word travels as two host accesses, low byte first; the byte-phase flag records that the low byte has been moved, and the second access finishes the word and drops the request. When it is set, each access moves only the low byte and finishes at once. On the core side, a word written into the data register raises the request. A read of the data register that the core marks as a handshake read also raises it. Core writes to the status register cannot disturb the handshake flags or the other protected bits.

Top module: `host_dr_port`

## Requirements
- R1: After reset the status register and the data register are both zero, so a status read returns 0x00.
- R2: A host read with hostSel=0 returns status bits [15:8], where bit 15 is the request flag, bit 12 is the byte-phase flag and bit 10 is the width-select bit. The read changes no state.
- R3: A host write with hostSel=0 changes neither the data register nor the status register.
- R4: With width-select 0 and byte-phase 0, a data access (hostSel=1) moves data bits [7:0] and sets byte-phase.
- R5: With width-select 0 and byte-phase 1, a data access moves data bits [15:8] and clears both byte-phase and request.
- R6: With width-select 1, every data access moves data bits [7:0] only and clears request. A host write leaves data bits [15:8] unchanged.
- R7: A core write to the data register loads all 16 bits, sets request and clears byte-phase.
- R8: A flagged core read of the data register sets request.
- R9: A core write to the status register keeps the bits under mask 0x907c and takes every other bit from the written value.
- R10: When a core write to the data register and a host data access fall in the same cycle, the core write wins. The host byte is dropped and byte-phase ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostSel | input | 1 | Host address: 0 status, 1 data |
| hostRd | input | 1 | Host read strobe, one access per cycle high |
| hostWr | input | 1 | Host write strobe, one access per cycle high |
| hostWdata | input | 8 | Host write byte |
| hostRdata | output | 8 | Host read byte, valid while hostRd is high |
| dspDrWe | input | 1 | Core write of the data register |
| dspDrWdata | input | 16 | Core write value for the data register |
| dspDrRdFlag | input | 1 | Core handshake read of the data register |
| dspSrWe | input | 1 | Core write of the status register |
| dspSrWdata | input | 16 | Core write value for the status register |
| dspDr | output | 16 | Data register contents toward the core |
| dspSr | output | 16 | Status register contents toward the core |

## Verification
The bench walks a word through both byte phases in each direction. A design that swapped the byte order, or that failed to clear the request flag on the second byte, would return the wrong byte or a stale status byte. It switches to single-byte mode and checks that the high data byte survives a host write and that repeated reads keep returning the low byte; a design that kept stepping the byte phase would hand out the high byte. It writes protected bits from the core side and checks that they stay unchanged. It also collides a core word write with a host byte write and checks that the core word and a cleared byte-phase win, where a wrong priority would leave a corrupted byte or a half-finished word.

// File: rtl/hbp_pkg.sv
package hbp_pkg;

  localparam int WORD_W  = 16;
  localparam int BYTE_W  = 8;
  localparam int RQM_BIT = 15;
  localparam int DRS_BIT = 12;
  localparam int DRC_BIT = 10;
  localparam logic [WORD_W-1:0] SR_KEEP = 16'h907c;

  // Strobes from the sequencer to the register datapath.
  typedef struct packed {
    logic dspLoadDr;   // core loads the whole data word
    logic dspLoadSr;   // core loads the unprotected status bits
    logic setRqm;      // raise request
    logic clrRqm;      // drop request (host finished a transfer)
    logic setDrs;      // first byte of a word moved
    logic clrDrs;      // word finished or restarted
    logic wrLow;       // host byte into data [7:0]
    logic wrHigh;      // host byte into data [15:8]
    logic rdHigh;      // host read selects data [15:8]
  } strobe_t;

endpackage

// File: rtl/hbp_ctrl.sv
module hbp_ctrl
  import hbp_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    hostSel,
  input  logic    hostRd,
  input  logic    hostWr,
  input  logic    dspDrWe,
  input  logic    dspDrRdFlag,
  input  logic    dspSrWe,
  input  logic    drsNow,
  input  logic    drcNow,
  output strobe_t stb
);

  logic dataAcc;
  logic hostWins;

  assign dataAcc  = hostSel & (hostRd | hostWr);
  assign hostWins = dataAcc & ~dspDrWe;

  always_comb begin
    stb           = '0;
    stb.dspLoadDr = dspDrWe;
    stb.dspLoadSr = dspSrWe;
    stb.setRqm    = dspDrWe | dspDrRdFlag;
    stb.clrDrs    = dspDrWe;
    stb.rdHigh    = ~drcNow & drsNow;
    if (hostWins) begin
      if (drcNow) begin
        stb.wrLow  = hostWr;
        stb.clrRqm = 1'b1;
      end else if (!drsNow) begin
        stb.wrLow  = hostWr;
        stb.setDrs = 1'b1;
      end else begin
        stb.wrHigh = hostWr;
        stb.clrDrs = 1'b1;
        stb.clrRqm = 1'b1;
      end
    end
  end

  // R3
  status_write_inert_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && !hostSel) |-> !(stb.wrLow || stb.wrHigh || stb.setDrs || stb.clrRqm));

  // R10
  dsp_priority_chk: assert property (@(posedge clk) disable iff (!rstN)
    dspDrWe |-> !(stb.wrLow || stb.wrHigh || stb.setDrs));

  // R6
  byte_mode_low_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    drcNow |-> !(stb.wrHigh || stb.setDrs || stb.rdHigh));

endmodule

// File: rtl/hbp_datapath.sv
module hbp_datapath
  import hbp_pkg::*;
#(
  parameter logic [WORD_W-1:0] KEEP_MASK = SR_KEEP
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              hostSel,
  input  logic [BYTE_W-1:0] hostWdata,
  input  logic [WORD_W-1:0] dspDrWdata,
  input  logic [WORD_W-1:0] dspSrWdata,
  output logic [BYTE_W-1:0] hostRdata,
  output logic [WORD_W-1:0] drReg,
  output logic [WORD_W-1:0] srReg
);

  localparam int LANES = WORD_W / BYTE_W;

  logic [WORD_W-1:0] drNext;
  logic [WORD_W-1:0] srNext;
  logic [LANES-1:0]  laneWe;

  assign laneWe[0] = stb.wrLow;
  assign laneWe[1] = stb.wrHigh;

  // Data register: core load overrides host byte lanes.
  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    always_comb begin
      if (stb.dspLoadDr)
        drNext[ln*BYTE_W +: BYTE_W] = dspDrWdata[ln*BYTE_W +: BYTE_W];
      else if (laneWe[ln])
        drNext[ln*BYTE_W +: BYTE_W] = hostWdata;
      else
        drNext[ln*BYTE_W +: BYTE_W] = drReg[ln*BYTE_W +: BYTE_W];
    end
  end

  // Status register: each bit is a handshake flag, a held bit or a core bit.
  for (genvar b = 0; b < WORD_W; b++) begin : g_srbit
    if (b == RQM_BIT) begin : g_rqm
      always_comb begin
        if (stb.setRqm)      srNext[b] = 1'b1;
        else if (stb.clrRqm) srNext[b] = 1'b0;
        else                 srNext[b] = srReg[b];
      end
    end else if (b == DRS_BIT) begin : g_drs
      always_comb begin
        if (stb.clrDrs)      srNext[b] = 1'b0;
        else if (stb.setDrs) srNext[b] = 1'b1;
        else                 srNext[b] = srReg[b];
      end
    end else if (KEEP_MASK[b]) begin : g_hold
      assign srNext[b] = srReg[b];
    end else begin : g_load
      assign srNext[b] = stb.dspLoadSr ? dspSrWdata[b] : srReg[b];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      drReg <= '0;
      srReg <= '0;
    end else begin
      drReg <= drNext;
      srReg <= srNext;
    end
  end

  always_comb begin
    if (!hostSel)        hostRdata = srReg[WORD_W-1 -: BYTE_W];
    else if (stb.rdHigh) hostRdata = drReg[WORD_W-1 -: BYTE_W];
    else                 hostRdata = drReg[BYTE_W-1:0];
  end

  // R7
  dsp_word_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.dspLoadDr |=> (drReg == $past(dspDrWdata)) && srReg[RQM_BIT] && !srReg[DRS_BIT]);

  // R5
  request_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrRqm && !stb.setRqm) |=> !srReg[RQM_BIT]);

  // R9
  protected_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.dspLoadSr && !stb.setRqm && !stb.clrRqm && !stb.setDrs && !stb.clrDrs)
    |=> ((srReg & KEEP_MASK) == ($past(srReg) & KEEP_MASK)));

  // R6
  high_byte_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrLow && !stb.dspLoadDr) |=> drReg[WORD_W-1 -: BYTE_W] == $past(drReg[WORD_W-1 -: BYTE_W]));

endmodule

// File: rtl/host_dr_port.sv
module host_dr_port
  import hbp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostSel,
  input  logic        hostRd,
  input  logic        hostWr,
  input  logic [7:0]  hostWdata,
  output logic [7:0]  hostRdata,
  input  logic        dspDrWe,
  input  logic [15:0] dspDrWdata,
  input  logic        dspDrRdFlag,
  input  logic        dspSrWe,
  input  logic [15:0] dspSrWdata,
  output logic [15:0] dspDr,
  output logic [15:0] dspSr
);

  strobe_t stb;

  hbp_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .hostSel     (hostSel),
    .hostRd      (hostRd),
    .hostWr      (hostWr),
    .dspDrWe     (dspDrWe),
    .dspDrRdFlag (dspDrRdFlag),
    .dspSrWe     (dspSrWe),
    .drsNow      (dspSr[DRS_BIT]),
    .drcNow      (dspSr[DRC_BIT]),
    .stb         (stb)
  );

  hbp_datapath #(.KEEP_MASK(SR_KEEP)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .hostSel    (hostSel),
    .hostWdata  (hostWdata),
    .dspDrWdata (dspDrWdata),
    .dspSrWdata (dspSrWdata),
    .hostRdata  (hostRdata),
    .drReg      (dspDr),
    .srReg      (dspSr)
  );

  // R2
  status_read_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && !hostSel && !hostWr && !dspDrWe && !dspSrWe && !dspDrRdFlag)
    |=> $stable(dspDr) && $stable(dspSr));

endmodule

// File: tb/host_dr_port_bench.sv
module host_dr_port_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostSel = 1'b0, hostRd = 1'b0, hostWr = 1'b0;
  logic [7:0]  hostWdata = '0;
  logic [7:0]  hostRdata;
  logic        dspDrWe = 1'b0, dspDrRdFlag = 1'b0, dspSrWe = 1'b0;
  logic [15:0] dspDrWdata = '0, dspSrWdata = '0;
  logic [15:0] dspDr, dspSr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] expQ[$];
  string      tagQ[$];

  // Bench model of the registers, from the requirements.
  logic [15:0] mDr = '0;
  logic [15:0] mSr = '0;

  always #10 clk = ~clk;   // 50 MHz

  host_dr_port u_host_dr_port (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostRd(hostRd), .hostWr(hostWr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .dspDrWe(dspDrWe),
    .dspDrWdata(dspDrWdata), .dspDrRdFlag(dspDrRdFlag), .dspSrWe(dspSrWe),
    .dspSrWdata(dspSrWdata), .dspDr(dspDr), .dspSr(dspSr)
  );

  // Monitor: compare every host read byte against the scoreboard.
  always @(negedge clk) begin
    #5;
    if (rstN && hostRd) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL unexpected read: actual %02h expected none", hostRdata);
      end else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (hostRdata !== e) begin
          errors++;
          $display("FAIL %s: read actual %02h expected %02h", t, hostRdata, e);
        end
      end
    end
  end

  // Model step for one host data access (bits: 15 request, 12 byte-phase, 10 width).
  function automatic logic [7:0] modelAccess(input bit isWr, input logic [7:0] b);
    logic [7:0] r;
    if (mSr[10]) begin
      r = mDr[7:0];
      if (isWr) mDr[7:0] = b;
      mSr[15] = 1'b0;
    end else if (!mSr[12]) begin
      r = mDr[7:0];
      if (isWr) mDr[7:0] = b;
      mSr[12] = 1'b1;
    end else begin
      r = mDr[15:8];
      if (isWr) mDr[15:8] = b;
      mSr[12] = 1'b0;
      mSr[15] = 1'b0;
    end
    return r;
  endfunction

  task automatic hostRead(input bit sel, input string tag);
    @(negedge clk);
    hostSel = sel; hostRd = 1'b1;
    if (sel) expQ.push_back(modelAccess(1'b0, 8'h00));
    else     expQ.push_back(mSr[15:8]);
    tagQ.push_back(tag);
    @(negedge clk);
    hostRd = 1'b0;
  endtask

  task automatic hostWrite(input bit sel, input logic [7:0] b);
    logic [7:0] unused;
    @(negedge clk);
    hostSel = sel; hostWr = 1'b1; hostWdata = b;
    if (sel) unused = modelAccess(1'b1, b);
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic dspWriteDr(input logic [15:0] v);
    @(negedge clk);
    dspDrWe = 1'b1; dspDrWdata = v;
    mDr = v; mSr[15] = 1'b1; mSr[12] = 1'b0;
    @(negedge clk);
    dspDrWe = 1'b0;
  endtask

  task automatic dspWriteSr(input logic [15:0] v);
    @(negedge clk);
    dspSrWe = 1'b1; dspSrWdata = v;
    mSr = (mSr & 16'h907c) | (v & ~16'h907c);
    @(negedge clk);
    dspSrWe = 1'b0;
  endtask

  task automatic dspFlagRead();
    @(negedge clk);
    dspDrRdFlag = 1'b1;
    mSr[15] = 1'b1;
    @(negedge clk);
    dspDrRdFlag = 1'b0;
  endtask

  // Core word write and host byte write in the same cycle.
  task automatic collide(input logic [15:0] v, input logic [7:0] b);
    @(negedge clk);
    dspDrWe = 1'b1; dspDrWdata = v;
    hostSel = 1'b1; hostWr = 1'b1; hostWdata = b;
    mDr = v; mSr[15] = 1'b1; mSr[12] = 1'b0;
    @(negedge clk);
    dspDrWe = 1'b0; hostWr = 1'b0;
  endtask

  task automatic checkDr(input logic [15:0] e, input string tag);
    @(negedge clk);
    #5;
    checks++;
    if (dspDr !== e) begin
      errors++;
      $display("FAIL %s: data register actual %04h expected %04h", tag, dspDr, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    hostRead(1'b0, "R1 reset status");
    checkDr(16'h0000, "R1 reset data");

    dspWriteDr(16'hA55A);
    hostRead(1'b0, "R7 request after core write");
    hostRead(1'b0, "R2 status reread unchanged");
    checkDr(16'hA55A, "R7 core word loaded");

    hostRead(1'b1, "R4 first byte low");
    hostRead(1'b0, "R4 byte-phase set");
    hostRead(1'b1, "R5 second byte high");
    hostRead(1'b0, "R5 flags cleared");

    dspFlagRead();
    hostRead(1'b0, "R8 flagged read raises request");
    hostWrite(1'b1, 8'h34);
    hostWrite(1'b1, 8'h12);
    checkDr(16'h1234, "R5 two-byte host write");
    hostRead(1'b0, "R5 request dropped after write");

    hostWrite(1'b0, 8'hFF);
    hostRead(1'b0, "R3 status write ignored");
    checkDr(16'h1234, "R3 data untouched");

    dspWriteSr(16'hFFFF);
    hostRead(1'b0, "R9 masked status load");
    dspWriteDr(16'hBEEF);
    hostRead(1'b0, "R7 request in byte mode");
    hostRead(1'b1, "R6 byte mode read low");
    hostRead(1'b0, "R6 request cleared");
    hostRead(1'b1, "R6 byte mode read low again");
    hostWrite(1'b1, 8'h77);
    checkDr(16'hBE77, "R6 high byte kept");

    dspWriteSr(16'h0000);
    dspWriteSr(16'h9000);
    hostRead(1'b0, "R9 protected bits not written");

    hostWrite(1'b1, 8'h11);
    hostRead(1'b0, "R4 byte-phase after first write");
    collide(16'hCAFE, 8'h22);
    checkDr(16'hCAFE, "R10 core word wins");
    hostRead(1'b0, "R10 byte-phase cleared");
    hostRead(1'b1, "R10 next access is low byte");

    repeat (3) @(negedge clk);
    if (expQ.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", expQ.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule